// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target

This block sits on a two-wire I2C bus as a target and answers like a small serial EEPROM. It sees SCL and SDA through plain inputs and pulls SDA low through a single output enable, so the surrounding pad logic supplies the open-drain behaviour. Storage is an internal byte array whose size, `MEM_BYTES`, is a parameter.

The size fixes how offsets are addressed. Arrays of 128 to 2048 bytes take one word-address byte. Arrays of 512, 1024 and 2048 bytes also take offset bits [10:8] from the low one, two or three bits of the device address, and those bits are then left out of the address match. Arrays of 4096 bytes and more take two word-address bytes, high byte first, and compare all seven device-address bits. A controller writes one byte with START, the address with write, the word address, one data byte and STOP. It reads by writing the word address, then sending a repeated START with the read bit set. A read that starts without a word address returns the byte after the last one accessed.

After each committed write the target is busy for `WRITE_CYCLES` clocks, which stands for the nominal 10 ms programming time and is shortened in simulation. While it is busy it does not acknowledge its own address, so a controller can poll it.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 7'h50 OR `DEV_SEL` on every compared bit. Any other address is not acknowledged, and the target ignores the bus until the next START.
- R2: With `MEM_BYTES` from 128 to 2048, one word-address byte follows the device address. For 512, 1024 and 2048 bytes, device-address bits [1], [2:1] or [3:1] of the first byte are not compared, and they become offset bits [8], [9:8] or [10:8].
- R3: With `MEM_BYTES` of 4096 or more, two word-address bytes follow, high byte first, and all seven device-address bits are compared.
- R4: In a write, the target acknowledges the device address, each word-address byte and the first data byte. The data byte is stored only when STOP arrives. A second data byte is not acknowledged and is not stored.
- R5: A repeated START with the read bit set (address byte bit 0 = 1) after a word-address write returns the byte at that offset, most significant bit first.
- R6: The offset pointer advances by one after every data byte, whether written or read, and wraps to 0 past `MEM_BYTES`-1. A read without a word address returns the byte at the pointer.
- R7: For `WRITE_CYCLES` clocks after a write commits, the target does not acknowledge its address. After that time it acknowledges again.
- R8: When the controller does not acknowledge a read byte, the target releases SDA and sends no further bits until the next START.
- R9: Reset releases SDA, clears the busy state and sets the pointer to 0. Memory contents survive reset.
- R10: The target changes SDA only while SCL is low, except that START and STOP release it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A bus edge reaches the control logic two clocks after the line moves, and `sda_oe` follows one clock later. The target's SDA therefore settles three clocks after the SCL falling edge that triggered it. The bench holds each SCL phase for at least five clocks, reads acknowledge and data bits five clocks after it raises SCL, and reads each data bit a second time five clocks later to confirm that SDA held steady through the high phase. A committed byte is written on the clock after STOP is detected, and busy starts on that same clock. The busy test therefore sends the next address byte at once, finishing about 185 clocks into a 300-clock busy time. It then waits the full busy time plus margin before expecting an acknowledge.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int          MEM_BYTES    = 256,
  parameter logic [6:0]  BASE_ADDR    = 7'h50,
  parameter logic [2:0]  DEV_SEL      = 3'd0,
  parameter int          WRITE_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int         AW       = $clog2(MEM_BYTES);
  localparam bit         WIDE     = (MEM_BYTES >= 4096);
  localparam int         NB       = WIDE ? 0 : ((AW > 8) ? AW - 8 : 0);
  localparam logic [6:0] CMP_MASK = 7'(7'h7F << NB);
  localparam logic [6:0] MY_ADDR  = BASE_ADDR | {4'b0000, DEV_SEL};
  localparam int         BW       = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {P_IDLE, P_DEV, P_WHI, P_WLO, P_WDAT, P_RD, P_WAIT} phase_t;

  phase_t          phase;
  logic [2:0]      scl_sy, sda_sy;
  logic [3:0]      cnt;
  logic            in_ack, rw, wr_pend;
  logic [7:0]      shreg, hi_byte, wdata;
  logic [2:0]      dev_low;
  logic [AW-1:0]   ptr;
  logic [BW-1:0]   busy_cnt;
  logic [7:0]      mem [MEM_BYTES];

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, rx, addr_hit;
  logic [7:0]  rd_byte;
  logic [15:0] word_full;

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_sy[1] & ~scl_sy[2];
  assign scl_fall  = ~scl_sy[1] & scl_sy[2];
  assign start_ev  = scl_sy[1] & scl_sy[2] & sda_sy[2] & ~sda_sy[1];
  assign stop_ev   = scl_sy[1] & scl_sy[2] & ~sda_sy[2] & sda_sy[1];
  assign busy      = (busy_cnt != '0);
  assign rx        = (phase == P_DEV) || (phase == P_WHI) || (phase == P_WLO) || (phase == P_WDAT);
  assign addr_hit  = (((shreg[7:1] ^ MY_ADDR) & CMP_MASK) == 7'd0);
  assign word_full = WIDE ? {hi_byte, shreg} : {5'b00000, dev_low, shreg};
  assign rd_byte   = mem[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy   <= '1;
      sda_sy   <= '1;
      phase    <= P_IDLE;
      cnt      <= '0;
      in_ack   <= 1'b0;
      rw       <= 1'b0;
      wr_pend  <= 1'b0;
      shreg    <= '0;
      hi_byte  <= '0;
      wdata    <= '0;
      dev_low  <= '0;
      ptr      <= '0;
      busy_cnt <= '0;
      sda_oe   <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      if (busy) busy_cnt <= busy_cnt - BW'(1);

      if (start_ev) begin
        phase   <= P_DEV;
        cnt     <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
      end else if (stop_ev) begin
        phase   <= P_IDLE;
        cnt     <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
        if (wr_pend) begin
          ptr      <= ptr + AW'(1);
          busy_cnt <= BW'(WRITE_CYCLES);
        end
      end else if (scl_rise) begin
        if (rx && cnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_s};
          cnt   <= cnt + 4'd1;
        end else if (phase == P_RD && in_ack) begin
          ptr <= ptr + AW'(1);
          if (sda_s) phase <= P_WAIT;
        end
      end else if (scl_fall) begin
        if (rx && !in_ack && cnt == 4'd8) begin
          case (phase)
            P_DEV:
              if (addr_hit && !busy) begin
                sda_oe  <= 1'b1;
                in_ack  <= 1'b1;
                rw      <= shreg[0];
                dev_low <= shreg[3:1];
              end else begin
                phase <= P_IDLE;
              end
            P_WHI: begin
              sda_oe  <= 1'b1;
              in_ack  <= 1'b1;
              hi_byte <= shreg;
            end
            P_WLO: begin
              sda_oe <= 1'b1;
              in_ack <= 1'b1;
              ptr    <= AW'(word_full);
            end
            P_WDAT: begin
              sda_oe  <= 1'b1;
              in_ack  <= 1'b1;
              wdata   <= shreg;
              wr_pend <= 1'b1;
            end
            default: ;
          endcase
        end else if (rx && in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          sda_oe <= 1'b0;
          case (phase)
            P_DEV:
              if (rw) begin
                phase  <= P_RD;
                sda_oe <= ~rd_byte[7];
                cnt    <= 4'd1;
              end else begin
                phase <= WIDE ? P_WHI : P_WLO;
              end
            P_WHI:  phase <= P_WLO;
            P_WLO:  phase <= P_WDAT;
            P_WDAT: phase <= P_WAIT;
            default: ;
          endcase
        end else if (phase == P_RD) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= 4'd1;
            sda_oe <= ~rd_byte[7];
          end else if (cnt < 4'd8) begin
            sda_oe <= ~rd_byte[~cnt[2:0]];
            cnt    <= cnt + 4'd1;
          end else begin
            sda_oe <= 1'b0;
            in_ack <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stop_ev && wr_pend) mem[ptr] <= wdata;
  end

  // R7
  ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DEV && busy) |-> !sda_oe);

  // R7
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_ev && wr_pend) |-> busy);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_IDLE) |-> !sda_oe);

  // R8
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_WAIT) |-> !sda_oe);

  // R10
  scl_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev || stop_ev)) |-> $stable(sda_oe));

endmodule

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;

  localparam int WC = 300;
  localparam int H  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic [1:0] drv = 2'b00;
  logic       oe0, oe1;
  logic [1:0] line;
  int         bsel = 0;
  int         checks = 0, fails = 0, glitches = 0;
  bit         done = 1'b0;

  int    exp_q[$];
  string req_q[$];
  int    obs_val;
  event  obs_ev;

  always #4 clk = ~clk;

  assign line[0] = ~(drv[0] | oe0);
  assign line[1] = ~(drv[1] | oe1);

  i2c_eeprom_target #(.MEM_BYTES(2048), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line[0]), .sda_oe(oe0));

  i2c_eeprom_target #(.MEM_BYTES(4096), .DEV_SEL(3'd5), .WRITE_CYCLES(WC)) uut_wide (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line[1]), .sda_oe(oe1));

  always @(obs_ev) begin
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL scoreboard empty: actual %0h expected none", obs_val);
    end else begin
      automatic int    e = exp_q.pop_front();
      automatic string r = req_q.pop_front();
      if (obs_val != e) begin
        fails++;
        $display("FAIL %s: actual %0h expected %0h", r, obs_val, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(input string r, input int v);
    exp_q.push_back(v);
    req_q.push_back(r);
  endtask

  task automatic observe(input int v);
    obs_val = v;
    -> obs_ev;
    tick(1);
  endtask

  task automatic bstart();
    drv[bsel] = 1'b0; tick(H);
    scl = 1'b1;       tick(H);
    drv[bsel] = 1'b1; tick(H);
    scl = 1'b0;       tick(H);
  endtask

  task automatic bstop();
    drv[bsel] = 1'b1; tick(H);
    scl = 1'b1;       tick(H);
    drv[bsel] = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      drv[bsel] = ~b[i]; tick(H);
      scl = 1'b1;        tick(2*H);
      scl = 1'b0;        tick(H);
    end
    drv[bsel] = 1'b0; tick(H);
    scl = 1'b1;       tick(H);
    ack = ~line[bsel];
    tick(H);
    scl = 1'b0;       tick(H);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      automatic logic s1;
      drv[bsel] = 1'b0; tick(H);
      scl = 1'b1;       tick(H);
      s1 = line[bsel];  tick(H);
      if (line[bsel] != s1) glitches++;
      d[i] = s1;
      scl = 1'b0;       tick(H);
    end
    drv[bsel] = give_ack; tick(H);
    scl = 1'b1;           tick(2*H);
    scl = 1'b0;           tick(H);
    drv[bsel] = 1'b0;
  endtask

  task automatic sx(input string r, input logic [7:0] v, input bit exp_ack);
    bit a;
    send_byte(v, a);
    expect_v(r, int'(exp_ack));
    observe(int'(a));
  endtask

  task automatic rxc(input string r, input bit give_ack, input int exp_d);
    logic [7:0] d;
    recv_byte(give_ack, d);
    expect_v(r, exp_d);
    observe(int'(d));
  endtask

  task automatic wr(input string r, input logic [7:0] dev, input bit two,
                    input logic [15:0] a, input logic [7:0] d, input bit wait_busy);
    bstart();
    sx(r, dev, 1'b1);
    if (two) sx(r, a[15:8], 1'b1);
    sx(r, a[7:0], 1'b1);
    sx(r, d, 1'b1);
    bstop();
    if (wait_busy) tick(WC + 50);
  endtask

  task automatic rd(input string r, input logic [7:0] dev, input bit two,
                    input logic [15:0] a, input int exp_d);
    bstart();
    sx(r, dev, 1'b1);
    if (two) sx(r, a[15:8], 1'b1);
    sx(r, a[7:0], 1'b1);
    bstart();
    sx(r, dev | 8'h01, 1'b1);
    rxc(r, 1'b0, exp_d);
    bstop();
  endtask

  initial begin
    tick(8 * 200000 / 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1..: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(10);
    rst_n = 1'b1;
    tick(10);

    // R9: SDA released after reset
    expect_v("R9", 3);
    observe(int'(line));

    // narrow array: 2048 bytes, one word byte, three block bits
    bsel = 0;
    // R1: foreign address ignored, next byte also ignored
    bstart();
    sx("R1", 8'h60, 1'b0);
    sx("R1", 8'h00, 1'b0);
    bstop();
    tick(20);

    // R2 R4: block 5, offset 0x3C
    wr("R4", 8'hAA, 1'b0, 16'h003C, 8'h96, 1'b0);
    // R7: busy right after commit
    bstart();
    sx("R7", 8'hA0, 1'b0);
    bstop();
    tick(WC + 50);
    bstart();
    sx("R7", 8'hA0, 1'b1);
    bstop();
    tick(20);

    // R2: same word byte, block 2
    wr("R2", 8'hA4, 1'b0, 16'h003C, 8'h11, 1'b1);
    rd("R5", 8'hAA, 1'b0, 16'h003C, 8'h96);
    rd("R2", 8'hA4, 1'b0, 16'h003C, 8'h11);

    // R4: second data byte refused and not stored
    wr("R4", 8'hA0, 1'b0, 16'h0011, 8'h44, 1'b1);
    bstart();
    sx("R4", 8'hA0, 1'b1);
    sx("R4", 8'h10, 1'b1);
    sx("R4", 8'h22, 1'b1);
    sx("R4", 8'h33, 1'b0);
    bstop();
    tick(WC + 50);
    rd("R4", 8'hA0, 1'b0, 16'h0011, 8'h44);
    rd("R4", 8'hA0, 1'b0, 16'h0010, 8'h22);

    // R6: current-address read continues after 0x10
    bstart();
    sx("R6", 8'hA1, 1'b1);
    rxc("R6", 1'b0, 8'h44);
    bstop();

    // R6: sequential read with controller acknowledge
    bstart();
    sx("R6", 8'hA0, 1'b1);
    sx("R6", 8'h10, 1'b1);
    bstart();
    sx("R6", 8'hA1, 1'b1);
    rxc("R6", 1'b1, 8'h22);
    rxc("R6", 1'b0, 8'h44);
    // R8: no more bits after the refused byte
    rxc("R8", 1'b0, 8'hFF);
    bstop();

    // wide array: 4096 bytes, address 0x55, two word bytes
    bsel = 1;
    // R3: neighbour address 0x54 refused
    bstart();
    sx("R3", 8'hA8, 1'b0);
    bstop();
    tick(20);
    wr("R3", 8'hAA, 1'b1, 16'h00BC, 8'h01, 1'b1);
    wr("R3", 8'hAA, 1'b1, 16'h0ABC, 8'h7E, 1'b1);
    rd("R3", 8'hAA, 1'b1, 16'h0ABC, 8'h7E);
    rd("R3", 8'hAA, 1'b1, 16'h00BC, 8'h01);

    // R6: wrap from the last location to 0
    wr("R6", 8'hAA, 1'b1, 16'h0FFF, 8'h5A, 1'b1);
    wr("R6", 8'hAA, 1'b1, 16'h0000, 8'hC3, 1'b1);
    bstart();
    sx("R6", 8'hAA, 1'b1);
    sx("R6", 8'h0F, 1'b1);
    sx("R6", 8'hFF, 1'b1);
    bstart();
    sx("R6", 8'hAB, 1'b1);
    rxc("R6", 1'b1, 8'h5A);
    rxc("R6", 1'b0, 8'hC3);
    bstop();

    // R9: reset during busy clears busy and pointer, keeps memory
    wr("R9", 8'hAA, 1'b1, 16'h0000, 8'hD7, 1'b0);
    tick(5);
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    bstart();
    sx("R9", 8'hAB, 1'b1);
    rxc("R9", 1'b0, 8'hD7);
    bstop();
    tick(20);

    // R10: data held steady while SCL high
    expect_v("R10", 0);
    observe(glitches);

    tick(10);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard R1: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule